// File: doc/BRIEF.md
# Priority-Sorted Interrupt Controller

The controller gathers 28 level-sensitive interrupt request lines and reduces them to one winning request for the processor core. Each line has a 4-bit priority. Most lines read it from a nibble of one of three 16-bit programmable priority words. Three external lines read it from a fixed constant word instead. Several lines can share one nibble.

The block does not compare priorities on every cycle. It keeps a mapping that places the request lines into a pending vector sorted by priority. The highest priority sits at the top bit, and among equal priorities the lower source index sits higher. Arbitration is then a single search for the highest set bit in that vector, after it is ANDed with a vector decoded from the core's 4-bit interrupt mask. The mapping is rebuilt one source per cycle after reset and after every write to a priority word. Outputs stay invalid while the rebuild runs. The result is registered and presented as an active flag, a source index, an event code and a one-cycle request pulse.

Top module: `prio_sort_intc`

## Requirements
- R1: While reset is asserted, all outputs read zero. After reset is released, the outputs stay zero for the initial mapping build, which takes 16*28+2 clock cycles, whatever the request lines do.
- R2: Priority-word select values are 0=word A, 1=word B and 2=word C. Nibble n of a word is bits 4n+3..4n. Each source takes its priority from this field:

  | Sources | Field |
  |---|---|
  | 3 | C nibble 0 |
  | 4 | C nibble 3 |
  | 5..9 | C nibble 2 |
  | 10 | A nibble 3 |
  | 11 | A nibble 2 |
  | 12..13 | A nibble 1 |
  | 14..16 | A nibble 0 |
  | 17..20 | B nibble 1 |
  | 21..24 | C nibble 1 |
  | 25 | B nibble 3 |
  | 26 | B nibble 2 |
  | 27 | A nibble 2 |

  All three words reset to zero.
- R3: Sources 0, 1 and 2 take nibbles 0, 1 and 2 of the fixed word 0x0246. Their priorities are therefore 6, 4 and 2, and no write changes them.
- R4: Sources that share a field always carry the same priority. Writing that field changes the priority of all of them at once.
- R5: With stable inputs, the winner is the requesting source of highest priority. Two clock edges after the inputs change, irq_act_o is 1, irq_src_o holds the winner's index and irq_evt_o holds 0x400 + 0x20*index.
- R6: Among requesting sources of equal priority, the lowest source index wins.
- R7: A source whose priority is less than or equal to imask_i never wins. A source of priority 0 therefore never raises a request.
- R8: A write with select 0, 1 or 2 updates the chosen word and forces all outputs to zero from the second edge after the write until the mapping has been rebuilt (16*28+2 cycles). A write with select 3 changes nothing, and the current winner stays on the outputs.
- R9: irq_req_o is high for exactly one cycle when irq_act_o rises, or when irq_src_o changes while irq_act_o stays high. It is low otherwise.
- R10: When no source is eligible, irq_act_o, irq_src_o and irq_evt_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | 28 | Level-sensitive request lines, bit i = source i |
| imask_i | input | 4 | Core interrupt mask level |
| wr_en_i | input | 1 | Priority word write strobe |
| wr_sel_i | input | 2 | Priority word select (0=A, 1=B, 2=C, 3=none) |
| wr_data_i | input | 16 | Priority word write data |
| irq_req_o | output | 1 | One-cycle request pulse toward the core |
| irq_act_o | output | 1 | A winning source is present |
| irq_src_o | output | 5 | Winning source index |
| irq_evt_o | output | 12 | Winning source event code |

## Verification
The bench targets ties inside shared priority fields. A design that placed equal priorities in the wrong order would report the higher index. It probes the mask boundary with the mask equal to the priority, and one below it. An off-by-one compare lets a blocked source through, or blocks a legal one. It also checks priority-zero sources with the mask at zero, and the fixed priorities of the external lines. It writes the priority words, including the unused select, and confirms that outputs are blanked during a rebuild and are left alone by the ignored write. A builder that resumed early would expose a half-built mapping. Finally, it holds inputs steady to confirm that the request pulse lasts one cycle, and that it fires again when the winner changes while the flag stays high.

// File: rtl/psi_pkg.sv
package psi_pkg;
    localparam int NUM_SRC = 28;
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int PRIO_W = 4;
    localparam int NUM_LVL = 1 << PRIO_W;
    localparam int WORD_W = 16;
    localparam int EVT_W = 12;
    localparam logic [WORD_W-1:0] FIXED_PRIO_WORD = 16'h0246;
    localparam logic [EVT_W-1:0] EVT_BASE = 12'h400;

    typedef enum logic [1:0] {
        FLD_A   = 2'd0,
        FLD_B   = 2'd1,
        FLD_C   = 2'd2,
        FLD_FIX = 2'd3
    } fld_sel_e;

    typedef struct packed {
        fld_sel_e   sel;
        logic [1:0] nib;
    } fld_t;

    // Where each source finds its priority nibble.
    function automatic fld_t src_field(input int idx);
        fld_t f;
        f.sel = FLD_FIX;
        f.nib = 2'd0;
        case (idx)
            0:                  begin f.sel = FLD_FIX; f.nib = 2'd0; end
            1:                  begin f.sel = FLD_FIX; f.nib = 2'd1; end
            2:                  begin f.sel = FLD_FIX; f.nib = 2'd2; end
            3:                  begin f.sel = FLD_C;   f.nib = 2'd0; end
            4:                  begin f.sel = FLD_C;   f.nib = 2'd3; end
            5, 6, 7, 8, 9:      begin f.sel = FLD_C;   f.nib = 2'd2; end
            10:                 begin f.sel = FLD_A;   f.nib = 2'd3; end
            11, 27:             begin f.sel = FLD_A;   f.nib = 2'd2; end
            12, 13:             begin f.sel = FLD_A;   f.nib = 2'd1; end
            14, 15, 16:         begin f.sel = FLD_A;   f.nib = 2'd0; end
            17, 18, 19, 20:     begin f.sel = FLD_B;   f.nib = 2'd1; end
            21, 22, 23, 24:     begin f.sel = FLD_C;   f.nib = 2'd1; end
            25:                 begin f.sel = FLD_B;   f.nib = 2'd3; end
            26:                 begin f.sel = FLD_B;   f.nib = 2'd2; end
            default:            begin f.sel = FLD_FIX; f.nib = 2'd3; end
        endcase
        return f;
    endfunction

    function automatic logic [PRIO_W-1:0] src_prio(
        input int               idx,
        input logic [WORD_W-1:0] wa,
        input logic [WORD_W-1:0] wb,
        input logic [WORD_W-1:0] wc
    );
        fld_t              f;
        logic [WORD_W-1:0] w;
        f = src_field(idx);
        case (f.sel)
            FLD_A:   w = wa;
            FLD_B:   w = wb;
            FLD_C:   w = wc;
            default: w = FIXED_PRIO_WORD;
        endcase
        return w[{f.nib, 2'b00} +: PRIO_W];
    endfunction

    function automatic logic [EVT_W-1:0] src_event(input logic [SRC_W-1:0] s);
        return EVT_BASE + {{(EVT_W-SRC_W-5){1'b0}}, s, 5'b00000};
    endfunction
endpackage

// File: rtl/psi_prio_regs.sv
module psi_prio_regs
    import psi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b,
    output logic [WORD_W-1:0] word_c,
    output logic              wr_hit
);
    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wr_hit = 1'b0;
        if (wr_en) begin
            case (fld_sel_e'(wr_sel))
                FLD_A:   begin st_d.a = wr_data; wr_hit = 1'b1; end
                FLD_B:   begin st_d.b = wr_data; wr_hit = 1'b1; end
                FLD_C:   begin st_d.c = wr_data; wr_hit = 1'b1; end
                default: wr_hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_a = st_q.a;
    assign word_b = st_q.b;
    assign word_c = st_q.c;
endmodule

// File: rtl/psi_sort_builder.sv
module psi_sort_builder
    import psi_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter int SW   = SRC_W,
    parameter int TAIL = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [WORD_W-1:0]         word_a,
    input  logic [WORD_W-1:0]         word_b,
    input  logic [WORD_W-1:0]         word_c,
    output logic                      busy,
    output logic [N-1:0][SW-1:0]      slot_src,
    output logic [N-1:0][PRIO_W-1:0]  slot_lvl
);
    localparam int TW = $clog2(TAIL + 1);

    typedef struct packed {
        logic                     scan;
        logic [TW-1:0]            tail;
        logic [PRIO_W-1:0]        lvl;
        logic [SW-1:0]            idx;
        logic [SW-1:0]            pos;
        logic [N-1:0][SW-1:0]     src;
        logic [N-1:0][PRIO_W-1:0] plv;
    } bld_t;

    bld_t st_d, st_q;
    logic [PRIO_W-1:0] cur_prio;

    always_comb begin
        st_d     = st_q;
        cur_prio = src_prio(int'(st_q.idx), word_a, word_b, word_c);
        if (start) begin
            st_d.scan = 1'b1;
            st_d.tail = '0;
            st_d.lvl  = PRIO_W'(NUM_LVL - 1);
            st_d.idx  = '0;
            st_d.pos  = SW'(N - 1);
        end else if (st_q.scan) begin
            // Place the current source if it belongs to the level being filled.
            if (cur_prio == st_q.lvl) begin
                st_d.src[st_q.pos] = st_q.idx;
                st_d.plv[st_q.pos] = st_q.lvl;
                st_d.pos           = st_q.pos - 1'b1;
            end
            if (st_q.idx == SW'(N - 1)) begin
                st_d.idx = '0;
                if (st_q.lvl == '0) begin
                    st_d.scan = 1'b0;
                    st_d.tail = TW'(TAIL);
                end else begin
                    st_d.lvl = st_q.lvl - 1'b1;
                end
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (st_q.tail != '0) begin
            st_d.tail = st_q.tail - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.scan <= 1'b1;
            st_q.lvl  <= PRIO_W'(NUM_LVL - 1);
            st_q.pos  <= SW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.scan || (st_q.tail != '0);
    assign slot_src = st_q.src;
    assign slot_lvl = st_q.plv;
endmodule

// File: rtl/psi_arbiter.sv
module psi_arbiter
    import psi_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int SW = SRC_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              irq,
    input  logic [PRIO_W-1:0]         imask,
    input  logic                      hold,
    input  logic [N-1:0][SW-1:0]      slot_src,
    input  logic [N-1:0][PRIO_W-1:0]  slot_lvl,
    output logic                      act,
    output logic                      req,
    output logic [SW-1:0]             src,
    output logic [EVT_W-1:0]          evt
);
    typedef struct packed {
        logic [N-1:0]      pend;
        logic [N-1:0]      lvok;
        logic              act;
        logic              req;
        logic [SW-1:0]     src;
        logic [EVT_W-1:0]  evt;
    } arb_t;

    arb_t st_d, st_q;
    logic [N-1:0]  masked;
    logic [SW-1:0] win_slot;
    logic [SW-1:0] win_src;
    logic          any;

    always_comb begin
        st_d = st_q;
        // Sorted pending vector and decoded mask vector.
        for (int s = 0; s < N; s++) begin
            st_d.pend[s] = irq[slot_src[s]];
            st_d.lvok[s] = slot_lvl[s] > imask;
        end
        masked   = st_q.pend & st_q.lvok;
        any      = 1'b0;
        win_slot = '0;
        for (int s = 0; s < N; s++) begin
            if (masked[s]) begin
                win_slot = SW'(s);
                any      = 1'b1;
            end
        end
        win_src  = slot_src[win_slot];
        st_d.act = any && !hold;
        st_d.src = st_d.act ? win_src : '0;
        st_d.evt = st_d.act ? src_event(win_src) : '0;
        st_d.req = st_d.act && (!st_q.act || (st_d.src != st_q.src));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act = st_q.act;
    assign req = st_q.req;
    assign src = st_q.src;
    assign evt = st_q.evt;
endmodule

// File: rtl/prio_sort_intc.sv
module prio_sort_intc
    import psi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [PRIO_W-1:0]  imask_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    output logic               irq_req_o,
    output logic               irq_act_o,
    output logic [SRC_W-1:0]   irq_src_o,
    output logic [EVT_W-1:0]   irq_evt_o
);
    logic [WORD_W-1:0]               word_a, word_b, word_c;
    logic                            wr_hit;
    logic                            rebuild_busy;
    logic [NUM_SRC-1:0][SRC_W-1:0]   slot_src;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  slot_lvl;

    psi_prio_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .word_a  (word_a),
        .word_b  (word_b),
        .word_c  (word_c),
        .wr_hit  (wr_hit)
    );

    psi_sort_builder #(.N(NUM_SRC), .SW(SRC_W), .TAIL(2)) u_build (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (wr_hit),
        .word_a   (word_a),
        .word_b   (word_b),
        .word_c   (word_c),
        .busy     (rebuild_busy),
        .slot_src (slot_src),
        .slot_lvl (slot_lvl)
    );

    psi_arbiter #(.N(NUM_SRC), .SW(SRC_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq      (irq_i),
        .imask    (imask_i),
        .hold     (rebuild_busy),
        .slot_src (slot_src),
        .slot_lvl (slot_lvl),
        .act      (irq_act_o),
        .req      (irq_req_o),
        .src      (irq_src_o),
        .evt      (irq_evt_o)
    );
endmodule

// File: rtl/psi_checker.sv
module psi_checker
    import psi_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             busy,
    input logic             act,
    input logic             req,
    input logic [SRC_W-1:0] src,
    input logic [EVT_W-1:0] evt
);
    p_req_needs_act_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> act);

    p_req_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !$past(act)) |-> req);

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (src == '0 && evt == '0));

    p_evt_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (evt == EVT_BASE + {{(EVT_W-SRC_W-5){1'b0}}, src, 5'b00000}));

    p_src_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (src < SRC_W'(NUM_SRC)));

    p_blank_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !act);

    p_write_blanks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != 2'd3) |-> ##2 !act);
endmodule

bind prio_sort_intc psi_checker u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en_i),
    .wr_sel (wr_sel_i),
    .busy   (rebuild_busy),
    .act    (irq_act_o),
    .req    (irq_req_o),
    .src    (irq_src_o),
    .evt    (irq_evt_o)
);

// File: tb/sim_prio_sort_intc.sv
module sim_prio_sort_intc;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 28;
    localparam int REBUILD = 16 * NS + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] irq = '0;
    logic [3:0]  imask = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req, act;
    logic [4:0]  src;
    logic [11:0] evt;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] ma = '0, mb = '0, mc = '0;
    bit prev_act = 0;
    int prev_src = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_sort_intc u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .imask_i(imask),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .irq_req_o(req), .irq_act_o(act), .irq_src_o(src), .irq_evt_o(evt)
    );

    function automatic int field_of(input int i);
        // returns sel*4 + nibble, per R2/R3
        case (i)
            0: return 12; 1: return 13; 2: return 14;
            3: return 8; 4: return 11;
            5, 6, 7, 8, 9: return 10;
            10: return 3; 11, 27: return 2; 12, 13: return 1; 14, 15, 16: return 0;
            17, 18, 19, 20: return 5;
            21, 22, 23, 24: return 9;
            25: return 7; 26: return 6;
            default: return 15;
        endcase
    endfunction

    function automatic int bprio(input int i);
        int f; logic [15:0] w;
        f = field_of(i);
        case (f / 4)
            0: w = ma; 1: w = mb; 2: w = mc; default: w = 16'h0246;
        endcase
        return int'((w >> (4 * (f % 4))) & 16'hF);
    endfunction

    function automatic void model(input logic [NS-1:0] r, input logic [3:0] m,
                                  output bit a, output int s);
        int bp;
        a = 0; s = 0; bp = 0;
        for (int i = 0; i < NS; i++) begin
            int p;
            p = bprio(i);
            if (r[i] && p > int'(m) && (!a || p > bp)) begin
                a = 1; s = i; bp = p;
            end
        end
    endfunction

    task automatic check(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
        end
    endtask

    task automatic sync_prev();
        bit a; int s;
        model(irq, imask, a, s);
        prev_act = a; prev_src = s;
    endtask

    task automatic apply(input string tag, input logic [NS-1:0] r, input logic [3:0] m);
        bit a; int s; int er;
        irq = r; imask = m;
        @(posedge clk); @(posedge clk); #1;
        model(r, m, a, s);
        er = (a && (!prev_act || s != prev_src)) ? 1 : 0;
        check({tag, " act"}, int'(act), int'(a));
        check({tag, " src"}, int'(src), a ? s : 0);
        check({tag, " evt"}, int'(evt), a ? (12'h400 + 32 * s) : 0);
        check({tag, " req R9"}, int'(req), er);
        prev_act = a; prev_src = s;
    endtask

    task automatic write_word(input int sel, input logic [15:0] d, input bit wait_build);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        case (sel) 0: ma = d; 1: mb = d; 2: mc = d; default: ; endcase
        if (wait_build) begin
            @(posedge clk); #1;
            if (sel != 3) check("R8 blank after write", int'(act), 0);
            repeat (REBUILD + 4) @(posedge clk);
            #1;
            sync_prev();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd7781);
        irq = '1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 reset act", int'(act), 0);
        check("R1 reset req", int'(req), 0);
        check("R1 reset src", int'(src), 0);
        rst_n = 1'b1;
        repeat (200) @(posedge clk);
        #1;
        check("R1 initial build blank", int'(act), 0);
        repeat (REBUILD) @(posedge clk);
        #1;
        sync_prev();

        // R3: fixed external priorities 6,4,2; all words zero (R7 prio 0)
        apply("R3 ext0", 28'h0000007, 4'd0);
        apply("R3 ext1 only", 28'h0000006, 4'd0);
        apply("R7 mask eq prio", 28'h0000004, 4'd2);
        apply("R7 mask below", 28'h0000004, 4'd1);
        apply("R7 prio0 blocked", 28'h0FFFFF8, 4'd0);
        apply("R10 none", 28'h0, 4'd0);

        // R2/R4: program words
        write_word(0, 16'h3A51, 1);   // A: n0=1 n1=5 n2=A n3=3
        write_word(1, 16'h7C90, 1);   // B: n1=9 n2=C n3=7
        write_word(2, 16'h0980, 1);   // C: n0=0 n1=8 n2=9 n3=0
        apply("R4 dma tie", 28'h0000280, 4'd0);      // 7,9 prio 9 -> 7 (R6)
        apply("R6 lower wins", 28'h0000220, 4'd0);   // 5,9
        apply("R2 rcmi vs rovi", 28'h8000800, 4'd3); // 11,27 prio A -> 11
        apply("R2 timer2", 28'h0003000, 4'd4);       // 12,13 prio5 -> 12
        apply("R2 serial", 28'h01E0000, 4'd0);       // prio9 -> 17
        apply("R2 refresh cmi", 28'h4000000, 4'd0);
        apply("R9 hold", 28'h4000000, 4'd0);
        apply("R9 change", 28'h4000001, 4'd11);      // 26 prio C beats
        apply("R7 mask C", 28'h4000001, 4'd12);      // -> ext0 prio6? blocked: none
        apply("R5 rtc", 28'h0014000, 4'd0);

        // R8: select 3 write ignored
        apply("R8 pre", 28'h0000100, 4'd0);
        write_word(3, 16'hFFFF, 0);
        @(posedge clk); @(posedge clk); #1;
        check("R8 sel3 act", int'(act), 1);
        check("R8 sel3 src", int'(src), 8);

        // Random rounds
        for (int rnd = 0; rnd < 4; rnd++) begin
            write_word(rnd % 3, 16'($urandom), 1);
            for (int k = 0; k < 150; k++) begin
                logic [NS-1:0] r;
                r = NS'($urandom);
                if (k % 3 == 0) r = r & NS'($urandom) & NS'($urandom);
                apply("R5 random", r, 4'($urandom % 16));
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule